// File: doc/BRIEF.md
# Microprogram Sequencer with Writable Control Store

This block is the control unit of a microprogrammed processor. It keeps a writable store of 512 microinstructions, each 36 bits wide, together with a microinstruction register and a microprogram counter. Every data-path cycle takes four clocks, one per named phase. In `PH_FETCH` the register is loaded from the store entry the counter points at. In `PH_DRIVE` the control fields leave the register and select a register for the B bus. In `PH_SETTLE` the ALU and shifter controls are held while the datapath settles. In `PH_COMMIT` the C-bus write enables and memory strobes fire, and the counter takes the next address. The phase transitions are fixed and unconditional: `PH_FETCH -> PH_DRIVE -> PH_SETTLE -> PH_COMMIT -> PH_FETCH`. Reset, at any time, returns the machine to `PH_FETCH`.

There is no sequential increment. Each microinstruction names its successor in a 9-bit next field. Three jump bits modify that field. One ORs the zero flag into address bit 8. One ORs the negative flag into bit 8. One ORs the 8-bit opcode byte held in the memory buffer into the low eight bits, which gives dispatch on the opcode. Memory strobes are issued in the commit phase, so the datapath receives read data during the next data-path cycle. The store is filled through a load port while reset is held.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst_n` is low the counter `upc_o` is 0 and every control output is 0.
- R2: A store write (`ld_en`, `ld_addr`, `ld_data`) takes effect only on a clock edge where `rst_n` is low. Writes while running are ignored.
- R3: After reset the phases run `PH_FETCH`, `PH_DRIVE`, `PH_SETTLE`, `PH_COMMIT`, one clock each, and repeat. In `PH_FETCH` the microinstruction register is loaded from the store entry addressed by `upc_o`.
- R4: The B-bus select field is word bits [3:0]. A code from 0 to 8 raises only `bsel_o[code]`. Codes 9 to 15 raise no line. `bsel_o` is zero in `PH_FETCH`.
- R5: The ALU field (bits [23:18]) drives `alu_o` and the shifter field (bits [17:16]) drives `shift_o` during `PH_DRIVE`, `PH_SETTLE` and `PH_COMMIT`. Both outputs are zero in `PH_FETCH`.
- R6: The C-enable field (bits [15:7]) drives `c_en_o`. Bit 6 drives `mem_wr_o`, bit 5 drives `mem_rd_o` and bit 4 drives `byte_fetch_o`. All of these are nonzero only in `PH_COMMIT`.
- R7: `upc_o` changes only on the clock edge that ends `PH_COMMIT`. With no jump bit set, it then takes the next field, bits [35:27].
- R8: If bit 24 is set and `z_flag` is 1 at the end of commit, the new `upc_o` has bit 8 set. If bit 25 is set and `n_flag` is 1, the new `upc_o` also has bit 8 set.
- R9: If bit 26 is set, `mbr_byte` sampled at the end of commit is ORed into bits [7:0] of the new `upc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also enables store loading |
| ld_en | input | 1 | Store write enable |
| ld_addr | input | 9 | Store write address |
| ld_data | input | 36 | Store write data |
| n_flag | input | 1 | ALU negative flag |
| z_flag | input | 1 | ALU zero flag |
| mbr_byte | input | 8 | Opcode byte for dispatch |
| upc_o | output | 9 | Microprogram counter |
| bsel_o | output | 9 | One-hot B-bus source select |
| alu_o | output | 6 | ALU function controls |
| shift_o | output | 2 | Shifter controls |
| c_en_o | output | 9 | C-bus register write enables |
| mem_rd_o | output | 1 | Word memory read strobe |
| mem_wr_o | output | 1 | Word memory write strobe |
| byte_fetch_o | output | 1 | Byte fetch strobe |

## Verification
The assertions assume that the flag and opcode inputs are stable around the commit edge. They also assume that reset is released only on a clock edge away from stimulus changes. The bench drives all inputs on the falling edge, so both conditions hold. The bench fills every store entry with pseudo-random words, which covers every B-select code, jump-bit combination and random flag and opcode values. While the sequencer runs, it also attempts store writes that a correct design must ignore.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
    localparam int unsigned CS_DEPTH = 512;
    localparam int unsigned NXT_W    = 9;
    localparam int unsigned ALU_W    = 6;
    localparam int unsigned SHF_W    = 2;
    localparam int unsigned NREG     = 9;
    localparam int unsigned BSEL_W   = 4;
    localparam int unsigned BYTE_W   = 8;

    typedef struct packed {
        logic [NXT_W-1:0]  nxt;
        logic              jmpc;
        logic              jamn;
        logic              jamz;
        logic [ALU_W-1:0]  alu;
        logic [SHF_W-1:0]  shf;
        logic [NREG-1:0]   cen;
        logic              wr;
        logic              rd;
        logic              fetch;
        logic [BSEL_W-1:0] bsel;
    } uinstr_t;

    localparam int unsigned WORD_W = $bits(uinstr_t);

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DRIVE  = 2'd1,
        PH_SETTLE = 2'd2,
        PH_COMMIT = 2'd3
    } phase_t;
endpackage

// File: rtl/ucs_store.sv
module ucs_store #(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned WIDTH = 36,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ucs_next_addr.sv
module ucs_next_addr #(
    parameter int unsigned AW     = 9,
    parameter int unsigned BYTE_W = 8
) (
    input  logic [AW-1:0]     nxt,
    input  logic              jmpc,
    input  logic              jamn,
    input  logic              jamz,
    input  logic              n_flag,
    input  logic              z_flag,
    input  logic [BYTE_W-1:0] mbr_byte,
    output logic [AW-1:0]     target
);
    logic              hi_or;
    logic [BYTE_W-1:0] lo_or;

    always_comb begin
        hi_or  = (jamn & n_flag) | (jamz & z_flag);
        lo_or  = jmpc ? mbr_byte : '0;
        target = nxt;
        target[AW-1]       = nxt[AW-1] | hi_or;
        target[BYTE_W-1:0] = nxt[BYTE_W-1:0] | lo_or;
    end
endmodule

// File: rtl/ucs_decode.sv
module ucs_decode
    import ucs_pkg::*;
(
    input  uinstr_t            mir,
    input  logic               drive_en,
    input  logic               commit_en,
    output logic [NREG-1:0]    bsel_o,
    output logic [ALU_W-1:0]   alu_o,
    output logic [SHF_W-1:0]   shift_o,
    output logic [NREG-1:0]    c_en_o,
    output logic               mem_rd_o,
    output logic               mem_wr_o,
    output logic               byte_fetch_o
);
    for (genvar g = 0; g < NREG; g++) begin : g_bsel
        assign bsel_o[g] = drive_en && (mir.bsel == BSEL_W'(g));
    end

    always_comb begin
        alu_o        = drive_en  ? mir.alu   : '0;
        shift_o      = drive_en  ? mir.shf   : '0;
        c_en_o       = commit_en ? mir.cen   : '0;
        mem_rd_o     = commit_en & mir.rd;
        mem_wr_o     = commit_en & mir.wr;
        byte_fetch_o = commit_en & mir.fetch;
    end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
    import ucs_pkg::*;
#(
    parameter int unsigned DEPTH = CS_DEPTH,
    localparam int unsigned AW   = NXT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [AW-1:0]     ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              n_flag,
    input  logic              z_flag,
    input  logic [BYTE_W-1:0] mbr_byte,
    output logic [AW-1:0]     upc_o,
    output logic [NREG-1:0]   bsel_o,
    output logic [ALU_W-1:0]  alu_o,
    output logic [SHF_W-1:0]  shift_o,
    output logic [NREG-1:0]   c_en_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic              byte_fetch_o
);
    phase_t            phase_q, phase_d;
    uinstr_t           mir_q;
    logic [AW-1:0]     mpc_q;
    logic [WORD_W-1:0] store_rd;
    logic [AW-1:0]     target;
    logic              fetch_en, drive_en, commit_en;

    ucs_store #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_store (
        .clk   (clk),
        .we    (ld_en & ~rst_n),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (mpc_q),
        .rdata (store_rd)
    );

    ucs_next_addr #(.AW(AW), .BYTE_W(BYTE_W)) u_next (
        .nxt      (mir_q.nxt),
        .jmpc     (mir_q.jmpc),
        .jamn     (mir_q.jamn),
        .jamz     (mir_q.jamz),
        .n_flag   (n_flag),
        .z_flag   (z_flag),
        .mbr_byte (mbr_byte),
        .target   (target)
    );

    ucs_decode u_dec (
        .mir          (mir_q),
        .drive_en     (drive_en),
        .commit_en    (commit_en),
        .bsel_o       (bsel_o),
        .alu_o        (alu_o),
        .shift_o      (shift_o),
        .c_en_o       (c_en_o),
        .mem_rd_o     (mem_rd_o),
        .mem_wr_o     (mem_wr_o),
        .byte_fetch_o (byte_fetch_o)
    );

    always_comb begin
        unique case (phase_q)
            PH_FETCH:  phase_d = PH_DRIVE;
            PH_DRIVE:  phase_d = PH_SETTLE;
            PH_SETTLE: phase_d = PH_COMMIT;
            PH_COMMIT: phase_d = PH_FETCH;
            default:   phase_d = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_FETCH;
        end else begin
            phase_q <= phase_d;
        end
    end

    always_comb begin
        fetch_en  = 1'b0;
        drive_en  = 1'b0;
        commit_en = 1'b0;
        unique case (phase_q)
            PH_FETCH:  fetch_en  = 1'b1;
            PH_DRIVE:  drive_en  = 1'b1;
            PH_SETTLE: drive_en  = 1'b1;
            PH_COMMIT: begin
                drive_en  = 1'b1;
                commit_en = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mir_q <= '0;
            mpc_q <= '0;
        end else begin
            if (fetch_en) begin
                mir_q <= uinstr_t'(store_rd);
            end
            if (commit_en) begin
                mpc_q <= target;
            end
        end
    end

    assign upc_o = mpc_q;
endmodule

// File: rtl/ucs_checker.sv
module ucs_checker
    import ucs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        phase,
    input logic [WORD_W-1:0] mir,
    input logic [NXT_W-1:0]  upc,
    input logic [NREG-1:0]   bsel,
    input logic [ALU_W-1:0]  alu,
    input logic [SHF_W-1:0]  shf,
    input logic [NREG-1:0]   cen,
    input logic              rd,
    input logic              wr,
    input logic              fetch,
    input logic              n_flag,
    input logic              z_flag,
    input logic [BYTE_W-1:0] mbr_byte
);
    uinstr_t m;
    assign m = uinstr_t'(mir);

    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (upc == '0 && bsel == '0 && alu == '0 &&
                                           shf == '0 && cen == '0 && !rd && !wr && !fetch);
        end
    end

    assert_phase_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH) |=> (phase == PH_DRIVE));

    assert_bsel_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bsel));

    assert_fetch_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH) |-> (alu == '0 && shf == '0 && bsel == '0));

    assert_commit_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cen != '0 || rd || wr || fetch) |-> (phase == PH_COMMIT));

    assert_upc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_COMMIT) |=> $stable(upc));

    assert_jamz_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_COMMIT && m.jamz && z_flag) |=> upc[NXT_W-1]);

    assert_jamn_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_COMMIT && m.jamn && n_flag) |=> upc[NXT_W-1]);

    assert_dispatch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_COMMIT && m.jmpc) |=>
            ((upc[BYTE_W-1:0] & $past(mbr_byte)) == $past(mbr_byte)));
endmodule

bind ucode_sequencer ucs_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase_q),
    .mir      (mir_q),
    .upc      (upc_o),
    .bsel     (bsel_o),
    .alu      (alu_o),
    .shf      (shift_o),
    .cen      (c_en_o),
    .rd       (mem_rd_o),
    .wr       (mem_wr_o),
    .fetch    (byte_fetch_o),
    .n_flag   (n_flag),
    .z_flag   (z_flag),
    .mbr_byte (mbr_byte)
);

// File: tb/ucode_sequencer_tb_top.sv
module ucode_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [8:0]  ld_addr = '0;
    logic [35:0] ld_data = '0;
    logic        n_flag = 1'b0;
    logic        z_flag = 1'b0;
    logic [7:0]  mbr_byte = '0;
    logic [8:0]  upc_o;
    logic [8:0]  bsel_o;
    logic [5:0]  alu_o;
    logic [1:0]  shift_o;
    logic [8:0]  c_en_o;
    logic        mem_rd_o, mem_wr_o, byte_fetch_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    logic [35:0] ref_mem [DEPTH];
    int          ref_ph  = 0;
    int          ref_pc  = 0;
    logic [35:0] ref_mir = '0;
    string       pc_tag  = "R7";
    string       run_tag = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    ucode_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .n_flag(n_flag), .z_flag(z_flag), .mbr_byte(mbr_byte), .upc_o(upc_o),
        .bsel_o(bsel_o), .alu_o(alu_o), .shift_o(shift_o), .c_en_o(c_en_o),
        .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .byte_fetch_o(byte_fetch_o)
    );

    function automatic logic [35:0] gen_word(int i, int seed);
        logic [31:0] a, b;
        a = 32'(i) * 32'h9E3779B1 + 32'(seed) * 32'h85EBCA6B;
        a = a ^ (a >> 15);
        b = a * 32'hC2B2AE35 + 32'h27D4EB2F;
        b = b ^ (b >> 13);
        return {b[3:0], a ^ b};
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model, advanced on each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            if (clk && ld_en) ref_mem[ld_addr] = ld_data;
            ref_ph = 0; ref_pc = 0; ref_mir = '0;
        end else begin
            if (ref_ph == 0) begin
                ref_mir = ref_mem[ref_pc];
            end else if (ref_ph == 3) begin
                int nx;
                nx = int'(ref_mir[35:27]);
                pc_tag = "R7";
                if ((ref_mir[24] && z_flag) || (ref_mir[25] && n_flag)) begin
                    nx = nx | 256; pc_tag = "R8";
                end
                if (ref_mir[26]) begin
                    nx = nx | int'(mbr_byte); pc_tag = {pc_tag, " R9"};
                end
                ref_pc = nx;
            end
            ref_ph = (ref_ph + 1) % 4;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                check("R1 upc", int'(upc_o), 0);
                check("R1 controls", int'({bsel_o, alu_o, shift_o, c_en_o,
                      mem_rd_o, mem_wr_o, byte_fetch_o}), 0);
            end else begin
                int eb, code;
                bit drv, cmt;
                drv  = (ref_ph != 0);
                cmt  = (ref_ph == 3);
                code = int'(ref_mir[3:0]);
                eb   = (drv && code < 9) ? (1 << code) : 0;
                check({run_tag, pc_tag, " upc"}, int'(upc_o), ref_pc);
                check({run_tag, "R4 bsel"}, int'(bsel_o), eb);
                check({run_tag, "R3 R5 alu"}, int'(alu_o), drv ? int'(ref_mir[23:18]) : 0);
                check({run_tag, "R5 shift"}, int'(shift_o), drv ? int'(ref_mir[17:16]) : 0);
                check({run_tag, "R6 c_en"}, int'(c_en_o), cmt ? int'(ref_mir[15:7]) : 0);
                check({run_tag, "R6 mem"}, int'({mem_wr_o, mem_rd_o, byte_fetch_o}),
                      cmt ? int'(ref_mir[6:4]) : 0);
            end
        end
    end

    task automatic load_all(int seed);
        for (int i = 0; i < DEPTH; i++) begin
            ld_en = 1'b1; ld_addr = 9'(i); ld_data = gen_word(i, seed);
            @(negedge clk);
        end
        ld_en = 1'b0;
    endtask

    task automatic run(int cycles, bit try_writes, int seed);
        for (int c = 0; c < cycles; c++) begin
            logic [31:0] r;
            r = gen_word(c, seed + 7)[31:0];
            n_flag = r[0]; z_flag = r[1]; mbr_byte = r[9:2];
            if (try_writes) begin
                ld_en = 1'b1; ld_addr = r[18:10]; ld_data = ~gen_word(c, seed);
            end else begin
                ld_en = 1'b0;
            end
            @(negedge clk);
        end
        ld_en = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        load_all(1);
        rst_n = 1'b1;
        run(3000, 1'b0, 11);
        // R2: writes while running must be ignored
        run_tag = "R2 ";
        run(3000, 1'b1, 23);
        run_tag = "";
        // reset mid-cycle, reload with new content while held (R1, R2)
        @(posedge clk); #1 rst_n = 1'b0;
        @(negedge clk);
        load_all(5);
        rst_n = 1'b1;
        run(3000, 1'b0, 31);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule